// File: doc/BRIEF.md
# Keyed Mode-Register Update Sequencer

This block is a host-side sequencer that updates a protected output-mode register in a data converter's control space. The protected register does not take a plain write. The host must first read the mode register (address 0x74) and the companion status register (address 0x75). It XORs the two readbacks, XORs that with the value it wants, and writes the resulting word back to 0x74. After that write, the register's effective contents equal the requested value.

A single-cycle `start` together with `desiredVal` launches the sequence. The block then acts as master on a simple register bus. Each access holds its strobe, address and write data steady until the target raises `busReady` on a clock edge. The mode register's bit 4 chooses between double and single data rate output. Single data rate is forbidden. If the requested value has bit 4 clear, the block still performs both reads, then skips the write and ends with `err` raised alongside `done`.

Top module: `mode_reg_updater`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `err`, `busRd` and `busWr` are all 0.
- R2: A `start` taken while idle first reads address 0x74 and then reads address 0x75, with one read of each. Each read keeps `busRd` high and `busAddr` steady until a cycle with `busReady` high.
- R3: No write is issued before both reads have completed.
- R4: When bit 4 of the desired value is 1, exactly one write is made. It goes to address 0x74 with data equal to (readback of 0x74) XOR (readback of 0x75) XOR desired. `busWr` and `busWdata` stay steady until `busReady`.
- R5: When bit 4 of the desired value is 0, no write is issued, and `err` is 1 in the cycle where `done` is 1. Otherwise `err` is 0 in that cycle.
- R6: `done` is a one-cycle pulse. `busy` is 1 from the cycle after `start` is sampled up to and including the `done` cycle, and is 0 in the cycle after it.
- R7: A `start` arriving while `busy` is 1 is ignored. It causes no extra bus access, and the value written is the one captured at the accepted start.
- R8: Let each bus access complete L cycles after its strobe first appears. The done cycle then begins 3L+4 clock edges after the start edge on the write path, and 2L+3 edges after it on the error path.
- R9: `busRd` and `busWr` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to update the mode register |
| desiredVal | input | DATA_W | Requested effective mode value, captured with `start` |
| busAddr | output | ADDR_W | Register bus address |
| busRd | output | 1 | Read strobe, held until `busReady` |
| busWr | output | 1 | Write strobe, held until `busReady` |
| busWdata | output | DATA_W | Write data, valid while `busWr` is 1 |
| busRdata | input | DATA_W | Read data, sampled when `busRd` and `busReady` are 1 |
| busReady | input | 1 | Target completes the current access at this clock edge |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Request refused (bit 4 clear); valid with `done` |
| busy | output | 1 | A sequence is in progress |

## Verification
Call the edge that samples `start` edge 0, and let every access take L wait cycles. The read of 0x74 completes at edge L+1 and the read of 0x75 at edge 2L+2. The compute step ends at edge 2L+3, and the write completes at edge 3L+4. `done` is therefore visible just after edge 3L+4 on the write path, or just after edge 2L+3 when the request is refused. The bench drives on falling edges and counts falling edges from the start. It expects `done` on exactly the (3L+5)th or the (2L+4)th falling edge, and checks for `busy` low on the falling edge after that. The bus model logs every completed access at the edge where it completes. The ordering, count and data checks read that log only after `done` has been seen.

// File: rtl/modeupd_pkg.sv
package modeupd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_MODE,
    ST_RD_STAT,
    ST_CALC,
    ST_WRITE,
    ST_DONE
  } seqState_t;

  typedef struct packed {
    logic loadDesired;
    logic capMode;
    logic capStat;
    logic drvWrite;
  } dpStrobe_t;

endpackage

// File: rtl/modeupd_ctrl.sv
module modeupd_ctrl
  import modeupd_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] MODE_ADDR = 8'h74,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h75
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              busReady,
  input  logic              guardOk,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busRd,
  output logic              busWr,
  output logic              done,
  output logic              err,
  output logic              busy,
  output dpStrobe_t         dpStrobe
);

  seqState_t state, stateNext;
  logic errQ;

  always_comb begin
    stateNext = state;
    dpStrobe  = '0;
    busAddr   = '0;
    busRd     = 1'b0;
    busWr     = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          dpStrobe.loadDesired = 1'b1;
          stateNext = ST_RD_MODE;
        end
      end
      ST_RD_MODE: begin
        busRd   = 1'b1;
        busAddr = MODE_ADDR;
        if (busReady) begin
          dpStrobe.capMode = 1'b1;
          stateNext = ST_RD_STAT;
        end
      end
      ST_RD_STAT: begin
        busRd   = 1'b1;
        busAddr = STAT_ADDR;
        if (busReady) begin
          dpStrobe.capStat = 1'b1;
          stateNext = ST_CALC;
        end
      end
      ST_CALC: begin
        stateNext = guardOk ? ST_WRITE : ST_DONE;
      end
      ST_WRITE: begin
        busWr = 1'b1;
        busAddr = MODE_ADDR;
        dpStrobe.drvWrite = 1'b1;
        if (busReady) stateNext = ST_DONE;
      end
      ST_DONE: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      errQ  <= 1'b0;
    end else begin
      state <= stateNext;
      if (state == ST_CALC) errQ <= !guardOk;
      else if (state == ST_IDLE) errQ <= 1'b0;
    end
  end

  assign done = (state == ST_DONE);
  assign err  = done && errQ;
  assign busy = (state != ST_IDLE);

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !(busRd && busWr)); // R9
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && !busReady) |=> (busRd && $stable(busAddr))); // R2
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && !busReady) |=> (busWr && $stable(busAddr))); // R4
  AST_WR_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    busWr |-> (busAddr == MODE_ADDR)); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R6
  AST_DONE_THEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy); // R6
  AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !guardOk && !busRd && !busWr && !done) |=> !busWr); // R5
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done && start) |=> busy); // R7

endmodule

// File: rtl/modeupd_dp.sv
module modeupd_dp
  import modeupd_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int GUARD_BIT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         dpStrobe,
  input  logic [DATA_W-1:0] desiredVal,
  input  logic [DATA_W-1:0] busRdata,
  output logic [DATA_W-1:0] busWdata,
  output logic              guardOk
);

  logic [DATA_W-1:0] desiredQ, modeQ, statQ, keyedWord;
  logic modeSeen, statSeen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      desiredQ <= '0;
      modeQ    <= '0;
      statQ    <= '0;
      modeSeen <= 1'b0;
      statSeen <= 1'b0;
    end else begin
      if (dpStrobe.loadDesired) begin
        desiredQ <= desiredVal;
        modeSeen <= 1'b0;
        statSeen <= 1'b0;
      end
      if (dpStrobe.capMode) begin
        modeQ    <= busRdata;
        modeSeen <= 1'b1;
      end
      if (dpStrobe.capStat) begin
        statQ    <= busRdata;
        statSeen <= 1'b1;
      end
    end
  end

  assign keyedWord = (modeQ ^ statQ) ^ desiredQ;
  assign guardOk   = desiredQ[GUARD_BIT];
  assign busWdata  = dpStrobe.drvWrite ? keyedWord : '0;

  AST_WR_AFTER_READS: assert property (@(posedge clk) disable iff (!rstN)
    dpStrobe.drvWrite |-> (modeSeen && statSeen)); // R3
  AST_WDATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (dpStrobe.drvWrite && !dpStrobe.loadDesired) |=> (!dpStrobe.drvWrite || $stable(busWdata))); // R4

endmodule

// File: rtl/mode_reg_updater.sv
module mode_reg_updater
  import modeupd_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int GUARD_BIT = 4,
  parameter logic [ADDR_W-1:0] MODE_ADDR = 8'h74,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h75
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [DATA_W-1:0] desiredVal,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busRd,
  output logic              busWr,
  output logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] busRdata,
  input  logic              busReady,
  output logic              done,
  output logic              err,
  output logic              busy
);

  dpStrobe_t dpStrobe;
  logic guardOk;

  modeupd_ctrl #(
    .ADDR_W(ADDR_W), .MODE_ADDR(MODE_ADDR), .STAT_ADDR(STAT_ADDR)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .busReady(busReady),
    .guardOk(guardOk), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .done(done), .err(err), .busy(busy), .dpStrobe(dpStrobe)
  );

  modeupd_dp #(
    .DATA_W(DATA_W), .GUARD_BIT(GUARD_BIT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .dpStrobe(dpStrobe), .desiredVal(desiredVal),
    .busRdata(busRdata), .busWdata(busWdata), .guardOk(guardOk)
  );

endmodule

// File: tb/mode_reg_updater_tb.sv
module mode_reg_updater_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [7:0] desiredVal = '0;
  logic [7:0] busAddr, busWdata, busRdata;
  logic busRd, busWr, busReady, done, err, busy;

  always #4 clk = ~clk;

  mode_reg_updater u_dut (
    .clk(clk), .rstN(rstN), .start(start), .desiredVal(desiredVal),
    .busAddr(busAddr), .busRd(busRd), .busWr(busWr), .busWdata(busWdata),
    .busRdata(busRdata), .busReady(busReady), .done(done), .err(err), .busy(busy)
  );

  // target model
  int latency = 0;
  int waitCnt = 0;
  logic [7:0] tgtMode = '0, tgtStat = '0, effLast = '0;
  logic [7:0] presetMode = '0, presetStat = '0;
  logic presetGo = 1'b0;
  int rdM = 0, rdS = 0, wrCnt = 0, orderBad = 0, bothCnt = 0;

  assign busReady = (busRd || busWr) && (waitCnt == latency);
  assign busRdata = (busAddr == 8'h74) ? tgtMode : (busAddr == 8'h75) ? tgtStat : 8'h00;

  always @(posedge clk) begin
    if ((busRd || busWr) && !busReady) waitCnt <= waitCnt + 1;
    else waitCnt <= 0;
    if (busRd && busWr) bothCnt <= bothCnt + 1;
    if (presetGo) begin
      tgtMode <= presetMode; tgtStat <= presetStat;
      rdM <= 0; rdS <= 0; wrCnt <= 0; orderBad <= 0;
    end else begin
      if (busRd && busReady) begin
        if (busAddr == 8'h74) begin
          if (rdM != 0) orderBad <= orderBad + 1;
          rdM <= rdM + 1;
        end else if (busAddr == 8'h75) begin
          if (rdM == 0) orderBad <= orderBad + 1;
          rdS <= rdS + 1;
        end else orderBad <= orderBad + 1;
      end
      if (busWr && busReady) begin
        if (rdM == 0 || rdS == 0 || busAddr != 8'h74) orderBad <= orderBad + 1;
        wrCnt   <= wrCnt + 1;
        effLast <= busWdata ^ tgtMode ^ tgtStat;
        tgtMode <= busWdata;
      end
    end
  end

  int tests = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic runOne(input int lat, input logic [7:0] d, input logic [7:0] m,
                        input logic [7:0] s, input bit pester);
    int k;
    int expK;
    bit expErr;
    latency = lat;
    @(negedge clk);
    presetMode = m; presetStat = s; presetGo = 1'b1;
    @(negedge clk);
    presetGo = 1'b0;
    start = 1'b1; desiredVal = d;
    expErr = !d[4];
    expK = expErr ? 2*lat + 4 : 3*lat + 5;
    k = 0;
    do begin
      @(negedge clk);
      k++;
      start = 1'b0;
      if (pester && k >= 2 && k < expK - 1) begin
        start = 1'b1; desiredVal = ~d & 8'hEF;
      end
      if (k == 1) chk(busy == 1'b1, "R6 busy after start", busy, 1);
    end while (!done && k < 80);
    start = 1'b0;
    chk(k == expK, "R8 done latency", k, expK);
    chk(err == expErr, "R5 err with done", err, expErr);
    @(negedge clk);
    chk(done == 1'b0, "R6 done one cycle", done, 0);
    chk(busy == 1'b0, "R6 busy drops", busy, 0);
    chk(rdM == 1 && rdS == 1, "R2 one read of each", rdM*16 + rdS, 17);
    chk(orderBad == 0, "R3 access order", orderBad, 0);
    if (expErr) begin
      chk(wrCnt == 0, "R5 no write", wrCnt, 0);
    end else begin
      chk(wrCnt == 1, "R4 one write", wrCnt, 1);
      chk(effLast == d, pester ? "R7 captured value kept" : "R4 effective value",
          effLast, d);
      chk(tgtMode == (m ^ s ^ d), "R4 raw word", tgtMode, m ^ s ^ d);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err && !busRd && !busWr, "R1 reset idle",
        {busy, done, err, busRd, busWr}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !busRd && !busWr, "R1 idle after reset", {busy, busRd, busWr}, 0);
    for (int lat = 0; lat < 3; lat++) begin
      for (int d = 0; d < 256; d++) begin
        runOne(lat, 8'(d), 8'((d * 37 + lat * 11) & 255), 8'(d ^ 8'h5C), 1'b0);
      end
    end
    runOne(1, 8'h35, 8'hA7, 8'h40, 1'b1); // R7
    runOne(2, 8'hD2, 8'h13, 8'h00, 1'b1); // R7
    runOne(0, 8'h05, 8'hFF, 8'hFF, 1'b1); // R7 on the refused path
    chk(bothCnt == 0, "R9 strobes exclusive", bothCnt, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule